// File: doc/BRIEF.md
# Word-to-Byte Read Bus Matcher

This block sits between the read port of a word-wide FIFO and a consumer whose bus can be configured narrower than the stored word. Each stored word is 18 bits wide. When the narrow output width is selected, the block holds one word and presents it as two 9-bit bytes, one per byte read. When the full width is selected, the words pass through unchanged. The output width and the byte order are captured while master reset is held and cannot change until the next reset.

The block pulls words from the FIFO with a single fetch strobe. It raises that strobe only once the held word has been fully consumed. As a result, the FIFO's fill accounting advances once per 18-bit word, whichever output width is in use. A byte read while nothing is held is ignored. A master reset discards any partly delivered word.

Top module: `word_byte_matcher`

## Requirements
- R1: `out_narrow_i` and `endian_sel_i` are sampled only on clock edges while `rst_ni` is low. Changing them after reset does not change the output width or the byte order.
- R2: With `out_narrow_i`=1 and `endian_sel_i`=0 at reset (big-endian), each word is delivered as two bytes on `data_o[8:0]`: first `word[17:9]`, then `word[8:0]`. `data_o[17:9]` reads zero in this mode.
- R3: With `out_narrow_i`=1 and `endian_sel_i`=1 at reset (little-endian), each word is delivered as `word[8:0]` first, then `word[17:9]`. `data_o[17:9]` reads zero.
- R4: In narrow mode, `fetch_o` stays low while a held word still has its second byte pending and that byte is not being read in the same cycle.
- R5: With `out_narrow_i`=0 at reset, `data_o` equals the held word and each accepted read consumes the whole word, for either endian setting.
- R6: A word is accepted on a rising edge where `fetch_o` and `word_valid_i` are both high. Exactly one word is accepted for every two bytes read in narrow mode, and for every read in wide mode.
- R7: While `data_valid_o` is low, `rd_en_i` has no effect. `data_valid_o` stays low until a word is accepted.
- R8: A master reset asserted after only the first byte of a word was read discards that word. The first byte after reset is the first byte of a newly accepted word.
- R9: Immediately after reset, `data_valid_o` is 0 and `fetch_o` is 1.
- R10: While `data_valid_o` is high and `rd_en_i` is low, `data_o` and `data_valid_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low master reset, asynchronous for data state |
| out_narrow_i | input | 1 | 1 selects 9-bit output; sampled during reset |
| endian_sel_i | input | 1 | 0 big-endian, 1 little-endian; sampled during reset |
| word_valid_i | input | 1 | FIFO has a word available on `word_i` |
| word_i | input | 18 | Word from FIFO |
| rd_en_i | input | 1 | Consumer reads the current byte or word |
| fetch_o | output | 1 | Pop strobe to FIFO; word taken when `word_valid_i` is also high |
| data_o | output | 18 | Output byte (in bits 8:0) or word |
| data_valid_o | output | 1 | `data_o` holds an unread byte or word |

## Verification
The assertions assume that the clock runs while reset is held, so that the configuration is captured before reset is released. They also assume that `word_i` is meaningful whenever `word_valid_i` is high. The stimulus therefore holds `rst_ni` low across several rising edges, with the configuration pins already set. It changes inputs only on falling edges and draws word values and handshake bits from a seeded random source. A scoreboard model derives the expected byte sequence and fetch timing from the configuration captured at reset, never from the pins' current levels.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic {
    ORD_BIG    = 1'b0,
    ORD_LITTLE = 1'b1
  } byte_order_e;

  typedef struct packed {
    logic        narrow;
    byte_order_e order;
  } mw_cfg_t;
endpackage

// File: rtl/mw_cfg_latch.sv
module mw_cfg_latch
  import mw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    narrow_i,
  input  logic    order_i,
  output mw_cfg_t cfg_o
);
  mw_cfg_t cfg_q;

  // captured on every edge while reset is held, frozen otherwise
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q.narrow <= narrow_i;
      cfg_q.order  <= byte_order_e'(order_i);
    end
  end

  assign cfg_o = cfg_q;

  p_cfg_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(cfg_q));
endmodule

// File: rtl/mw_word_hold.sv
module mw_word_hold
  import mw_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mw_cfg_t           cfg_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_en_i,
  output logic              fetch_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              full_o,
  output logic              second_o
);
  logic [WORD_W-1:0] hold_q;
  logic              full_q, second_q;
  logic              take_piece, last_piece, load;

  assign take_piece = rd_en_i & full_q;
  assign last_piece = take_piece & (~cfg_i.narrow | second_q);
  assign fetch_o    = ~full_q | last_piece;
  assign load       = fetch_o & word_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (load) begin
      hold_q   <= word_i;
      full_q   <= 1'b1;
      second_q <= 1'b0;
    end else if (last_piece) begin
      full_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (take_piece) begin
      second_q <= 1'b1;
    end
  end

  assign hold_o   = hold_q;
  assign full_o   = full_q;
  assign second_o = second_q;

  p_no_early_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.narrow && full_q && !second_q) |-> !fetch_o);

  p_wide_no_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.narrow |-> !second_q);

  p_empty_read_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_q && !word_valid_i) |=> !full_q);

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_en_i) |=> (full_q && $stable(hold_q) && $stable(second_q)));

  p_load_first_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && fetch_o) |=> (full_q && !second_q));
endmodule

// File: rtl/mw_half_sel.sv
module mw_half_sel
  import mw_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  mw_cfg_t           cfg_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              second_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] upper, lower, pick;
  logic              take_upper;

  assign upper = word_i[WORD_W-1:HALF_W];
  assign lower = word_i[HALF_W-1:0];

  // big-endian: upper first; little-endian: lower first
  assign take_upper = (cfg_i.order == ORD_BIG) ? ~second_i : second_i;
  assign pick       = take_upper ? upper : lower;

  always_comb begin
    if (cfg_i.narrow) data_o = {{(WORD_W-HALF_W){1'b0}}, pick};
    else              data_o = word_i;
  end
endmodule

// File: rtl/word_byte_matcher.sv
module word_byte_matcher
  import mw_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              out_narrow_i,
  input  logic              endian_sel_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_en_i,
  output logic              fetch_o,
  output logic [WORD_W-1:0] data_o,
  output logic              data_valid_o
);
  mw_cfg_t           cfg;
  logic [WORD_W-1:0] hold;
  logic              full, second;

  mw_cfg_latch u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .narrow_i (out_narrow_i),
    .order_i  (endian_sel_i),
    .cfg_o    (cfg)
  );

  mw_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .rd_en_i      (rd_en_i),
    .fetch_o      (fetch_o),
    .hold_o       (hold),
    .full_o       (full),
    .second_o     (second)
  );

  mw_half_sel #(.WORD_W(WORD_W)) u_sel (
    .cfg_i    (cfg),
    .word_i   (hold),
    .second_i (second),
    .data_o   (data_o)
  );

  assign data_valid_o = full;

  p_out_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !rd_en_i) |=> (data_valid_o && $stable(data_o)));

  p_narrow_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.narrow |-> (data_o[WORD_W-1:WORD_W/2] == '0));
endmodule

// File: tb/word_byte_matcher_tb_top.sv
module word_byte_matcher_tb_top;
  localparam int W = 18;
  localparam int H = W / 2;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         out_narrow_i = 1'b1, endian_sel_i = 1'b0;
  logic         word_valid_i = 1'b0, rd_en_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         fetch_o, data_valid_o;
  logic [W-1:0] data_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  int  pieces = 0;
  bit  m_narrow, m_little;
  int  words_in = 0, reads_out = 0;

  always #10 clk = ~clk;

  word_byte_matcher #(.WORD_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .out_narrow_i(out_narrow_i),
    .endian_sel_i(endian_sel_i), .word_valid_i(word_valid_i), .word_i(word_i),
    .rd_en_i(rd_en_i), .fetch_o(fetch_o), .data_o(data_o),
    .data_valid_o(data_valid_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes expected pieces when a word is accepted
  task automatic push_word(input logic [W-1:0] w);
    if (!m_narrow) exp_q.push_back(w);
    else if (!m_little) begin
      exp_q.push_back({{(W-H){1'b0}}, w[W-1:H]});
      exp_q.push_back({{(W-H){1'b0}}, w[H-1:0]});
    end else begin
      exp_q.push_back({{(W-H){1'b0}}, w[H-1:0]});
      exp_q.push_back({{(W-H){1'b0}}, w[W-1:H]});
    end
    pieces += m_narrow ? 2 : 1;
    words_in++;
  endtask

  // one cycle: drive at negedge, monitor compares, then advance
  task automatic cycle(input logic v, input logic [W-1:0] w, input logic r, input string req);
    logic exp_fetch;
    word_valid_i = v; word_i = w; rd_en_i = r;
    #1;
    exp_fetch = (pieces == 0) || (r && pieces == 1);
    chk("R7 valid", W'(data_valid_o), W'(pieces > 0));
    chk("R4/R6 fetch", W'(fetch_o), W'(exp_fetch));
    if (pieces > 0) begin
      chk(req, data_o, exp_q[0]);
      if (r) begin
        void'(exp_q.pop_front());
        pieces--;
        reads_out++;
      end
    end
    if (exp_fetch && v) push_word(w);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit narrow, input bit little);
    rst_ni = 1'b0;
    out_narrow_i = narrow; endian_sel_i = little;
    word_valid_i = 1'b0; rd_en_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_q.delete(); pieces = 0; words_in = 0; reads_out = 0;
    m_narrow = narrow; m_little = little;
    rst_ni = 1'b1;
    #1;
    chk("R9 valid", W'(data_valid_o), '0);
    chk("R9 fetch", W'(fetch_o), W'(1));
  endtask

  task automatic stream(input int n, input string req);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 4) != 0, W'($urandom), ($urandom % 3) != 0, req);
    for (int i = 0; i < 8; i++) cycle(1'b0, '0, 1'b1, req);
  endtask

  task automatic check_ratio(input string req);
    chk(req, W'(reads_out), W'(words_in * (m_narrow ? 2 : 1)));
  endtask

  initial begin
    void'($urandom(7));
    @(negedge clk);
    // narrow, big-endian
    do_reset(1'b1, 1'b0);
    stream(60, "R2 data");
    check_ratio("R6 narrow ratio");
    // hold with no reads
    cycle(1'b1, 18'h2_A5C3, 1'b0, "R10 data");
    for (int i = 0; i < 5; i++) cycle(1'b1, W'($urandom), 1'b0, "R10 data");
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1, "R2 data");
    // empty reads ignored
    for (int i = 0; i < 4; i++) cycle(1'b0, '0, 1'b1, "R7 data");
    cycle(1'b1, 18'h1_0F0F, 1'b0, "R7 data");
    cycle(1'b0, '0, 1'b1, "R7 data");
    cycle(1'b0, '0, 1'b1, "R7 data");
    // narrow, little-endian
    do_reset(1'b1, 1'b1);
    stream(60, "R3 data");
    check_ratio("R6 narrow ratio");
    // pins move after reset: model keeps captured setting
    out_narrow_i = 1'b0; endian_sel_i = 1'b0;
    stream(40, "R1 data");
    // wide, both endian settings
    do_reset(1'b0, 1'b0);
    stream(40, "R5 data");
    check_ratio("R6 wide ratio");
    do_reset(1'b0, 1'b1);
    stream(40, "R5 data");
    // reset mid-word
    do_reset(1'b1, 1'b0);
    cycle(1'b1, 18'h3_FE01, 1'b0, "R8 data");
    cycle(1'b0, '0, 1'b1, "R8 data");
    do_reset(1'b1, 1'b0);
    cycle(1'b1, 18'h0_8123, 1'b0, "R8 data");
    #1;
    chk("R8 first byte", data_o, 18'h0_0040);
    cycle(1'b0, '0, 1'b1, "R8 data");
    cycle(1'b0, '0, 1'b1, "R8 data");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule